// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block chooses which physical page frame to evict when a new page must be brought in. It keeps one "recently used" flag for each frame and a circular hand that points at the next candidate. Any memory access that touches a frame reports that frame on the reference port, which sets the frame's flag. When the memory manager needs a frame, it raises a replacement request. The engine then sweeps the hand one frame per clock. A flagged frame gets its flag cleared and keeps its place in memory for another round. The first unflagged frame becomes the victim.

The victim is offered on a valid/ready output. It stays on the port until the consumer accepts it. The request input is also valid/ready. `req_ready` is high only while the engine is idle, so a request held high while a victim is still pending waits without being lost. `vic_frame` is held stable while `vic_valid` is high and `vic_ready` is low.

A dirty-preference mode uses a per-frame dirty vector to favour clean frames, which need no write-back. During the first revolution, clean frames are preferred. After that revolution, dirty frames become eligible again.

Top module: `clock_repl_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `vic_valid` is 0, the hand points at frame 0 and every used flag is clear.
- R2: A `ref_valid` pulse with frame number F sets the used flag of frame F. This holds whether the engine is idle or sweeping.
- R3: While sweeping, the engine examines the frame under the hand once per cycle. A flagged frame has its flag cleared and the hand moves on. The first unflagged frame is chosen as the victim.
- R4: When a victim is chosen, its used flag is set and the hand is left on the next frame.
- R5: With no references during the sweep, `vic_valid` rises at most NFRAMES+1 cycles after the request is accepted. If every flag is set, the engine clears them all and chooses the frame where the hand started, exactly NFRAMES+1 cycles after acceptance.
- R6: `req_ready` is 1 only while no sweep is running and no victim is pending. `vic_valid` and `vic_frame` stay unchanged until `vic_ready` is 1.
- R7: A reference to the frame under the hand in the cycle that frame is examined prevents it from being chosen in that cycle, and its used flag stays set.
- R8: With `dirty_pref` = 1, during the first NFRAMES examinations, an unflagged frame whose `dirty_mask` bit (bit F for frame F) is 1 is passed over and its flag is left unchanged.
- R9: With `dirty_pref` = 1, if no clean unflagged frame is found in the first NFRAMES examinations, the next unflagged frame is chosen whatever its dirty bit.
- R10: With `dirty_pref` = 0, `dirty_mask` has no effect on the choice.
- R11: The hand wraps from frame NFRAMES-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_valid | input | 1 | A reference to `ref_frame` happened this cycle |
| ref_frame | input | 4 | Frame number of the reference |
| dirty_mask | input | 16 | Dirty bit of each frame, bit F for frame F |
| dirty_pref | input | 1 | 1 selects clean-first replacement |
| req_valid | input | 1 | Replacement request |
| req_ready | output | 1 | Engine can accept a request |
| vic_valid | output | 1 | A victim frame is offered |
| vic_ready | input | 1 | Consumer takes the offered victim |
| vic_frame | output | 4 | Chosen victim frame number |

## Verification
The sweep-length bound only holds if no references arrive while a sweep is running. The bound's checker therefore drops the bound for any sweep that sees a reference. The stimulus sends references only while the engine is idle, apart from a single directed case that targets the frame under the hand. `dirty_mask` and `dirty_pref` are assumed to stay stable from request to victim, and the bench changes them only while the engine is idle. The bench drives `ref_frame` only with values inside the frame range.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SWEEP = 2'd1,
    ENG_OFFER = 2'd2
  } eng_state_t;
endpackage

// File: rtl/clock_use_bits.sv
module clock_use_bits #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_en,
  input  logic [IDXW-1:0]    ref_idx,
  input  logic               mark_en,
  input  logic [IDXW-1:0]    mark_idx,
  input  logic               clr_en,
  input  logic [IDXW-1:0]    clr_idx,
  output logic [NFRAMES-1:0] use_q
);
  // Any set request beats a clear in the same cycle (R2, R7)
  for (genvar g = 0; g < NFRAMES; g++) begin : g_bit
    logic set_here, clr_here;
    assign set_here = (ref_en && ref_idx == IDXW'(g)) || (mark_en && mark_idx == IDXW'(g));
    assign clr_here = clr_en && clr_idx == IDXW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        use_q[g] <= 1'b0;
      else if (set_here) use_q[g] <= 1'b1;
      else if (clr_here) use_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/clock_hand.sv
module clock_hand #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES),
  parameter int CNTW    = $clog2(NFRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  output logic [IDXW-1:0] hand_q,
  output logic            second_pass
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NFRAMES - 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(NFRAMES);

  logic [CNTW-1:0] steps_q;

  // R11: circular wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hand_q <= '0;
    else if (step) hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        steps_q <= '0;
    else if (restart)                  steps_q <= '0;
    else if (step && steps_q != FULL)  steps_q <= steps_q + 1'b1;
  end

  assign second_pass = (steps_q == FULL);
endmodule

// File: rtl/clock_decide.sv
module clock_decide #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input  logic               active,
  input  logic [IDXW-1:0]    hand,
  input  logic [NFRAMES-1:0] use_bits,
  input  logic [NFRAMES-1:0] dirty_mask,
  input  logic               dirty_pref,
  input  logic               second_pass,
  input  logic               ref_en,
  input  logic [IDXW-1:0]    ref_idx,
  output logic               do_clear,
  output logic               do_pick
);
  logic ref_here, used, skip_dirty;

  assign ref_here   = ref_en && (ref_idx == hand);
  assign used       = use_bits[hand] || ref_here;           // R7
  assign skip_dirty = dirty_pref && !second_pass && dirty_mask[hand]; // R8, R9

  always_comb begin
    do_clear = 1'b0;
    do_pick  = 1'b0;
    if (active) begin
      if (used)             do_clear = !ref_here;            // R3
      else if (!skip_dirty) do_pick  = 1'b1;
    end
  end
endmodule

// File: rtl/clock_repl_engine.sv
module clock_repl_engine #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_valid,
  input  logic [IDXW-1:0]    ref_frame,
  input  logic [NFRAMES-1:0] dirty_mask,
  input  logic               dirty_pref,
  input  logic               req_valid,
  output logic               req_ready,
  output logic               vic_valid,
  input  logic               vic_ready,
  output logic [IDXW-1:0]    vic_frame
);
  import clock_repl_pkg::*;

  eng_state_t         state_q;
  logic [NFRAMES-1:0] use_q;
  logic [IDXW-1:0]    hand_q;
  logic               second_pass, do_clear, do_pick, sweeping, accept;

  assign sweeping  = (state_q == ENG_SWEEP);
  assign req_ready = (state_q == ENG_IDLE);   // R6
  assign vic_valid = (state_q == ENG_OFFER);
  assign accept    = req_valid && req_ready;

  clock_use_bits #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_use (
    .clk(clk), .rst_n(rst_n),
    .ref_en(ref_valid), .ref_idx(ref_frame),
    .mark_en(do_pick), .mark_idx(hand_q),      // R4
    .clr_en(do_clear), .clr_idx(hand_q),
    .use_q(use_q)
  );

  clock_hand #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_hand (
    .clk(clk), .rst_n(rst_n),
    .restart(accept), .step(sweeping),
    .hand_q(hand_q), .second_pass(second_pass)
  );

  clock_decide #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_decide (
    .active(sweeping), .hand(hand_q), .use_bits(use_q),
    .dirty_mask(dirty_mask), .dirty_pref(dirty_pref),
    .second_pass(second_pass),
    .ref_en(ref_valid), .ref_idx(ref_frame),
    .do_clear(do_clear), .do_pick(do_pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      vic_frame <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE:  if (accept) state_q <= ENG_SWEEP;
        ENG_SWEEP: if (do_pick) begin
                     state_q   <= ENG_OFFER;
                     vic_frame <= hand_q;
                   end
        ENG_OFFER: if (vic_ready) state_q <= ENG_IDLE;
        default:   state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_repl_checker.sv
module clock_repl_checker #(
  parameter int NFRAMES = 16,
  parameter int IDXW    = $clog2(NFRAMES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_valid,
  input logic [IDXW-1:0]    ref_frame,
  input logic               req_valid,
  input logic               req_ready,
  input logic               vic_valid,
  input logic               vic_ready,
  input logic [IDXW-1:0]    vic_frame,
  input logic [NFRAMES-1:0] use_q,
  input logic [IDXW-1:0]    hand_q
);
  localparam int CW = $clog2(NFRAMES + 2) + 1;
  logic [CW-1:0]   busy_cnt;
  logic            quiet_q;
  logic            busy;
  logic [IDXW-1:0] after_vic;

  assign busy      = !req_ready && !vic_valid;
  assign after_vic = (vic_frame == IDXW'(NFRAMES - 1)) ? '0 : vic_frame + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      quiet_q  <= 1'b0;
    end else if (req_valid && req_ready) begin
      busy_cnt <= '0;
      quiet_q  <= 1'b1;
    end else if (busy) begin
      if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
      if (ref_valid) quiet_q <= 1'b0;
    end
  end

  assert_ref_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> use_q[$past(ref_frame)]);

  assert_victim_marked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vic_valid) |-> (use_q[vic_frame] && hand_q == after_vic));

  assert_sweep_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && quiet_q) |-> (busy_cnt <= CW'(NFRAMES)));

  assert_offer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_frame)));

  assert_idle_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && vic_valid));
endmodule

bind clock_repl_engine clock_repl_checker #(.NFRAMES(NFRAMES), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
  .req_valid(req_valid), .req_ready(req_ready), .vic_valid(vic_valid),
  .vic_ready(vic_ready), .vic_frame(vic_frame), .use_q(use_q), .hand_q(hand_q)
);

// File: tb/clock_repl_engine_bench.sv
`timescale 1ns/1ps
module clock_repl_engine_bench;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_valid = 1'b0;
  logic [3:0]   ref_frame = '0;
  logic [N-1:0] dirty_mask = '0;
  logic         dirty_pref = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         vic_valid;
  logic         vic_ready = 1'b0;
  logic [3:0]   vic_frame;

  int n_checks = 0;
  int n_fails  = 0;
  bit mdl_use [N];
  int mdl_hand = 0;

  always #2.5 clk = ~clk;

  clock_repl_engine #(.NFRAMES(N)) u_clock_repl_engine (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .dirty_mask(dirty_mask), .dirty_pref(dirty_pref),
    .req_valid(req_valid), .req_ready(req_ready),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_frame(vic_frame)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Idle-time references (R2)
  task automatic touch(input logic [N-1:0] frames);
    for (int i = 0; i < N; i++) begin
      if (frames[i]) begin
        @(negedge clk); ref_valid = 1'b1; ref_frame = 4'(i);
        mdl_use[i] = 1'b1;
        @(posedge clk);
      end
    end
    @(negedge clk); ref_valid = 1'b0;
  endtask

  // One replacement; the policy model predicts victim and examination count
  task automatic replace(input string tag, input logic [N-1:0] dm, input bit pref,
                         input bit hit_en, input int hit_f, input int hold);
    int exp_v, exp_lat, lat, k;
    bit used, hit;
    if (hit_en && hit_f != mdl_hand) mdl_use[hit_f] = 1'b1;
    k = 0; exp_v = -1;
    while (exp_v < 0) begin
      k++;
      hit  = (k == 1) && hit_en && (hit_f == mdl_hand);
      used = mdl_use[mdl_hand] || hit;
      if (used) begin
        mdl_use[mdl_hand] = hit;
      end else if (!(pref && k <= N && dm[mdl_hand])) begin
        exp_v = mdl_hand;
        mdl_use[mdl_hand] = 1'b1;
      end
      mdl_hand = (mdl_hand + 1) % N;
    end
    exp_lat = k;

    @(negedge clk);
    dirty_mask = dm; dirty_pref = pref; req_valid = 1'b1;
    chk(req_ready == 1'b1, {tag, " R6 ready before request"}, req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit_en) begin ref_valid = 1'b1; ref_frame = 4'(hit_f); end
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk);
      ref_valid = 1'b0;
      lat++;
    end while (!vic_valid && lat < 60);
    chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    chk(vic_frame == 4'(exp_v), {tag, " victim"}, vic_frame, exp_v);
    for (int h = 0; h < hold; h++) begin
      req_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(vic_valid && vic_frame == 4'(exp_v), {tag, " R6 victim held"}, vic_frame, exp_v);
      chk(req_ready == 1'b0, {tag, " R6 no accept while pending"}, req_ready, 0);
    end
    req_valid = 1'b0; vic_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    vic_ready = 1'b0;
    chk(req_ready && !vic_valid, {tag, " R6 idle after take"}, vic_valid, 0);
  endtask

  task automatic t_reset;  // R1
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(vic_valid == 1'b0, "R1 vic_valid", vic_valid, 0);
    replace("R1 first victim frame 0", '0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_sweep;  // R2, R3
    touch(16'h000E);
    replace("R2 R3 skip referenced", '0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_hand_next;  // R4
    replace("R4 hand after victim", '0, 1'b0, 1'b0, 0, 3);
  endtask

  task automatic t_all_set;  // R5
    touch(16'hFFFF);
    replace("R5 full revolution", '0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_wrap;  // R11
    touch(16'hFF80);
    replace("R11 wrap to frame 0", '0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_ref_under_hand;  // R7
    replace("R7 reference under hand", '0, 1'b0, 1'b1, mdl_hand, 0);
  endtask

  task automatic t_dirty_pref;  // R8
    replace("R8 clean preferred", 16'h0038, 1'b1, 1'b0, 0, 0);
  endtask

  task automatic t_dirty_off;  // R10
    replace("R10 dirty ignored", 16'hFFFF, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_all_dirty;  // R9
    replace("R9 dirty after revolution", 16'hFFFF, 1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mdl_use[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_hand_next();
    t_all_set();
    t_wrap();
    t_ref_under_hand();
    t_dirty_pref();
    t_dirty_off();
    t_all_dirty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule